// File: doc/BRIEF.md
# Codec Power-Down and Wake Sequencer

This block is the control state machine that decides whether a PCM voice codec is running or parked in a low-power state. It watches an active-low power-down pin and the transmit and receive frame-sync strobes. It is clocked by the codec's internal sequencing clock, nominally 256 kHz, so one 8 kHz frame lasts 32 clocks. It drives three registered enables: a global power enable, one enable for the whole group of analog-side outputs, and a separate enable for the serial transmit data driver.

The codec powers down in two cases: when the pin is pulled low, or when both frame syncs stop producing rising edges for a configurable number of clocks. To wake, the pin must be high and a fresh rising edge must appear on either sync. After wake-up the analog outputs come up at once. The transmit data driver stays in high impedance until a set number of further transmit-sync edges have been counted.

All three asynchronous inputs pass through a multi-stage synchroniser. An input change therefore reaches the enables on the third rising clock edge after it is first sampled. Counting starts with the edge that first sees the new level.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three enables are 0 after that edge. After `rst` is released, the block stays powered down until a wake condition occurs.
- R2: `pd_n` low forces `pwr_en`, `ana_oe` and `dt_oe` to 0 on the third rising clock edge after the low level is first sampled, whatever the syncs are doing.
- R3: While `pd_n` is low, rising edges on either sync do not wake the block. Raising `pd_n` without a new sync edge does not wake it either.
- R4: With `pd_n` high, a rising edge on `fs_tx` or `fs_rx` sets `pwr_en` and `ana_oe` to 1 on the third rising clock edge after the sync's high level is first sampled. `dt_oe` stays 0 at that point. With no edge, the block stays down.
- R5: After wake-up, `dt_oe` becomes 1 on the third clock edge after the second `fs_tx` rising edge that follows the wake edge (WAKE_EDGES = 2). The wake edge itself and all `fs_rx` edges are not counted.
- R6: If neither sync shows a rising edge for IDLE_LIMIT = 64 clocks, all enables drop to 0. This happens on the 68th rising edge after the last sync high was first sampled; they are still 1 on the 67th.
- R7: A sync held high counts as one rising edge only. A constant level on both syncs counts as absence and leads to power-down as in R6.
- R8: Every power-down discards the count toward R5, so the next wake again needs two fresh `fs_tx` edges before `dt_oe` rises.
- R9: `ana_oe` always equals `pwr_en`, and `dt_oe` is 1 only while `pwr_en` is 1.
- R10: While `pd_n` is high and sync rising edges keep arriving less than IDLE_LIMIT clocks apart, the block stays powered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencing clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down request, active low, asynchronous |
| fs_tx | input | 1 | Transmit frame-sync strobe, asynchronous |
| fs_rx | input | 1 | Receive frame-sync strobe, asynchronous |
| pwr_en | output | 1 | Global power enable |
| ana_oe | output | 1 | Output enable for the analog-side output group |
| dt_oe | output | 1 | Output enable for the serial transmit data driver |

## Verification
The assertions assume that every sync rising edge is held for at least one clock, so the synchroniser never loses a pulse. They also assume that `rst` is high from time zero until after the first clock edge. The stimulus changes inputs only on falling clock edges and makes each sync pulse one full clock wide. Keep-alive pulses are spaced 32 clocks apart, well inside the 64-clock idle window, except where a test deliberately lets that window expire. A sweep covers zero to three transmit edges after a wake from either sync and compares `dt_oe` against the count computed in the bench.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

  typedef enum logic [1:0] {
    PS_DOWN   = 2'd0,
    PS_WAKE   = 2'd1,
    PS_ACTIVE = 2'd2
  } pwr_state_t;

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/cps_idle_watch.sv
module cps_idle_watch #(
  parameter int IDLE_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  output logic idle
);

  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  quiet_cnt <= '0;
    else if (activity)        quiet_cnt <= '0;
    else if (quiet_cnt != LIM) quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign idle = (quiet_cnt == LIM);

  // R10: any sync edge restarts the quiet window
  p_idle_clear_r10: assert property (@(posedge clk) disable iff (rst)
    activity |=> !idle);

endmodule

// File: rtl/cps_wake_fsm.sv
module cps_wake_fsm
  import codec_pwr_pkg::*;
#(
  parameter int WAKE_EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_ok,
  input  logic tx_rise,
  input  logic rx_rise,
  input  logic idle,
  output logic pwr_en,
  output logic ana_oe,
  output logic dt_oe
);

  localparam int WW = $clog2(WAKE_EDGES + 1);
  localparam logic [WW-1:0] LAST = WW'(WAKE_EDGES - 1);

  pwr_state_t      state, state_n;
  logic [WW-1:0]   tx_cnt, tx_cnt_n;
  logic            any_rise, drop;

  assign any_rise = tx_rise | rx_rise;
  assign drop     = !pd_ok || (idle && !any_rise);

  always_comb begin
    state_n  = state;
    tx_cnt_n = tx_cnt;
    case (state)
      PS_DOWN: begin
        tx_cnt_n = '0;
        if (pd_ok && any_rise) state_n = PS_WAKE;
      end
      PS_WAKE: begin
        if (drop) begin
          state_n  = PS_DOWN;
          tx_cnt_n = '0;
        end else if (tx_rise) begin
          if (tx_cnt == LAST) state_n = PS_ACTIVE;
          else                tx_cnt_n = tx_cnt + 1'b1;
        end
      end
      PS_ACTIVE: begin
        if (drop) begin
          state_n  = PS_DOWN;
          tx_cnt_n = '0;
        end
      end
      default: begin
        state_n  = PS_DOWN;
        tx_cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PS_DOWN;
      tx_cnt <= '0;
      pwr_en <= 1'b0;
      ana_oe <= 1'b0;
      dt_oe  <= 1'b0;
    end else begin
      state  <= state_n;
      tx_cnt <= tx_cnt_n;
      pwr_en <= (state_n != PS_DOWN);
      ana_oe <= (state_n != PS_DOWN);
      dt_oe  <= (state_n == PS_ACTIVE);
    end
  end

  // R1: reset parks everything
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (!pwr_en && !ana_oe && !dt_oe));

  // R2: pin low wins over every other input
  p_pin_forces_down_r2: assert property (@(posedge clk) disable iff (rst)
    !pd_ok |=> !pwr_en);

  // R3: no wake while the pin is held low
  p_no_wake_pin_low_r3: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && !pd_ok) |=> !pwr_en);

  // R4: waking needs a sync edge
  p_wake_needs_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && !any_rise) |=> !pwr_en);

  // R5: data driver turns on only at a transmit edge
  p_dt_on_tx_edge_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dt_oe) |-> $past(tx_rise));

  // R6: quiet window expiry powers down
  p_idle_down_r6: assert property (@(posedge clk) disable iff (rst)
    (idle && !any_rise) |=> !pwr_en);

  // R9: enable ordering
  p_enable_order_r9: assert property (@(posedge clk) disable iff (rst)
    (dt_oe |-> pwr_en) and (ana_oe == pwr_en));

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_LIMIT  = 64,
  parameter int WAKE_EDGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic fs_tx,
  input  logic fs_rx,
  output logic pwr_en,
  output logic ana_oe,
  output logic dt_oe
);

  localparam int NSYNC = 2;

  logic [NSYNC-1:0] fs_raw, fs_lvl, fs_prev, fs_rise;
  logic             pd_ok, idle;

  assign fs_raw = {fs_rx, fs_tx};

  cps_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
    .clk (clk),
    .rst (rst),
    .din (pd_n),
    .dout(pd_ok)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSYNC; gi++) begin : g_fs
      cps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (fs_raw[gi]),
        .dout(fs_lvl[gi])
      );

      always_ff @(posedge clk) begin
        if (rst) fs_prev[gi] <= 1'b0;
        else     fs_prev[gi] <= fs_lvl[gi];
      end

      assign fs_rise[gi] = fs_lvl[gi] & ~fs_prev[gi];

      // R7: a held level yields a single edge
      p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
        fs_rise[gi] |=> !fs_rise[gi]);
    end
  endgenerate

  cps_idle_watch #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .activity(|fs_rise),
    .idle    (idle)
  );

  cps_wake_fsm #(.WAKE_EDGES(WAKE_EDGES)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .pd_ok  (pd_ok),
    .tx_rise(fs_rise[0]),
    .rx_rise(fs_rise[1]),
    .idle   (idle),
    .pwr_en (pwr_en),
    .ana_oe (ana_oe),
    .dt_oe  (dt_oe)
  );

endmodule

// File: tb/sim_codec_pwr_seq.sv
`timescale 1ns/1ps
module sim_codec_pwr_seq;

  logic clk = 1'b0;
  logic rst, pd_n, fs_tx, fs_rx;
  logic pwr_en, ana_oe, dt_oe;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  codec_pwr_seq u0 (
    .clk   (clk),
    .rst   (rst),
    .pd_n  (pd_n),
    .fs_tx (fs_tx),
    .fs_rx (fs_rx),
    .pwr_en(pwr_en),
    .ana_oe(ana_oe),
    .dt_oe (dt_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {pwr_en, ana_oe, dt_oe};
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {pwr_en,ana_oe,dt_oe} actual=%b expected=%b at %0t",
               req, act, exp, $time);
    end
  endtask

  task automatic pulse_tx;
    fs_tx = 1'b1; tick(1); fs_tx = 1'b0;
  endtask

  task automatic pulse_rx;
    fs_rx = 1'b1; tick(1); fs_rx = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // R9: enable ordering watched every cycle outside reset
  always @(negedge clk) begin
    if (rst === 1'b0) begin
      vectors++;
      if ((dt_oe && !pwr_en) || (ana_oe !== pwr_en)) begin
        fails++;
        $display("FAIL R9: {pwr_en,ana_oe,dt_oe} actual=%b expected ordered enables",
                 {pwr_en, ana_oe, dt_oe});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; pd_n = 1'b0; fs_tx = 1'b0; fs_rx = 1'b0;
    tick(3);
    chk("R1 reset", 3'b000);
    rst = 1'b0;

    // stays down with pin high but no sync
    pd_n = 1'b1;
    tick(100);
    chk("R4 no edge", 3'b000);

    // pin low blocks wake
    pd_n = 1'b0;
    tick(3);
    pulse_rx(); tick(10);
    pulse_tx(); tick(10);
    chk("R3 pin low", 3'b000);
    pd_n = 1'b1;
    tick(5);
    chk("R3 pin rise alone", 3'b000);

    // wake on receive edge, exact cycle
    pulse_rx();
    tick(1);
    chk("R4 before wake", 3'b000);
    tick(1);
    chk("R4 wake", 3'b110);

    // receive keep-alive does not count toward data enable
    for (int i = 0; i < 4; i++) begin
      tick(29); pulse_rx(); tick(2);
      chk("R5 rx ignored / R10", 3'b110);
    end

    // two transmit edges
    tick(28); pulse_tx(); tick(2);
    chk("R5 first tx", 3'b110);
    tick(28); pulse_tx(); tick(1);
    chk("R5 before second", 3'b110);
    tick(1);
    chk("R5 second tx", 3'b111);

    // keep alive with transmit edges
    for (int i = 0; i < 10; i++) begin
      tick(29); pulse_tx(); tick(2);
      chk("R10 keep alive", 3'b111);
    end

    // idle expiry timing
    tick(29); pulse_tx();
    tick(66);
    chk("R6 before expiry", 3'b111);
    tick(1);
    chk("R6 expiry", 3'b000);

    // wake by transmit edge: wake edge not counted
    pulse_tx(); tick(2);
    chk("R8 tx wake", 3'b110);
    tick(29); pulse_tx(); tick(2);
    chk("R8 one tx", 3'b110);
    tick(28); pulse_tx(); tick(2);
    chk("R8 two tx", 3'b111);

    // pin low while active
    pd_n = 1'b0;
    tick(2);
    chk("R2 before", 3'b111);
    tick(1);
    chk("R2 down", 3'b000);

    // partial progress is discarded
    tick(3); pd_n = 1'b1; tick(3);
    pulse_rx(); tick(2);
    chk("R8 wake a", 3'b110);
    tick(28); pulse_tx(); tick(2);
    chk("R8 partial", 3'b110);
    pd_n = 1'b0; tick(3);
    chk("R2 wake state", 3'b000);
    pd_n = 1'b1; tick(3);
    pulse_rx(); tick(2);
    chk("R8 wake b", 3'b110);
    tick(28); pulse_tx(); tick(2);
    chk("R8 count restarted", 3'b110);
    tick(28); pulse_tx(); tick(2);
    chk("R8 full count", 3'b111);

    // held-high transmit sync
    pd_n = 1'b0; tick(3); pd_n = 1'b1; tick(3);
    pulse_rx(); tick(2);
    fs_tx = 1'b1;
    tick(40);
    chk("R7 held high one edge", 3'b110);
    tick(40);
    chk("R7 held high is idle", 3'b000);
    fs_tx = 1'b0;
    tick(3);

    // sweep: wake source x number of transmit edges
    for (int w = 0; w < 2; w++) begin
      for (int n = 0; n < 4; n++) begin
        pd_n = 1'b0; tick(3); pd_n = 1'b1; tick(2);
        if (w == 0) pulse_rx(); else pulse_tx();
        tick(2);
        for (int k = 0; k < n; k++) begin
          tick(20); pulse_tx(); tick(2);
        end
        tick(3);
        chk("R5 sweep", (n >= 2) ? 3'b111 : 3'b110);
      end
    end

    // reset while active
    rst = 1'b1; tick(1);
    chk("R1 reset active", 3'b000);
    rst = 1'b0; tick(5);
    chk("R1 stays down", 3'b000);

    finish_run();
  end

endmodule